// File: doc/BRIEF.md
# Learning-Candidate Lookup Chain

This block answers one question during the learning phase of a column-based sparse coding engine: is a given column index a member of the active set that the inhibition stage has just produced? Several channels issue such lookups. A small round-robin arbiter admits one lookup per cycle into a pipelined chain of compare stages. It has no stall input, because the chain accepts a new query on every cycle.

Each stage of the chain is bound to one entry of the active set, given as an index and a valid bit. A query moves one stage per cycle. A stage compares the query's column index with its own entry only when that entry is valid. On a match, the stage clears the query's valid bit, so later stages neither compare it again nor treat it as unresolved. A query that leaves the last stage still valid has matched nothing and counts as a miss (a timeout). Per-channel reporters send each outcome back to the channel that issued the query, as a one-cycle hit pulse or a one-cycle miss pulse. Each channel keeps at most one query in flight.

Top module: `lcam_top`

## Requirements
- R1: In every cycle `gnt_o` is zero or one-hot. It is set only for a channel whose `req_i` bit is high, and it is nonzero whenever any `req_i` bit is high. The grant is combinational in the same cycle as the request.
- R2: Grants rotate in round-robin order. The winner is the first requesting channel after the last granted channel in circular order (channel numbering 0..NUM_CH-1). After reset, channel 0 has the highest priority.
- R3: If a query is granted in cycle t and the lowest-numbered valid entry equal to its index is entry k (entry k sits at `ent_idx_i[k*IDX_W +: IDX_W]`), then `hit_o` of the issuing channel is high in cycle t+k+2 and in no other cycle for that query.
- R4: An entry whose `ent_vld_i` bit is low never matches, whatever index it holds.
- R5: If no valid entry equals the query index, then `miss_o` of the issuing channel is high only in cycle t+DEPTH+1.
- R6: A hit ends the query. Further valid entries holding the same index raise no second hit and no miss.
- R7: Every admitted query produces exactly one single-cycle pulse, either hit or miss, and only on the channel that issued it. `hit_o` and `miss_o` are never high together on a channel.
- R8: While `rst_n` is low, `hit_o` and `miss_o` are zero and no query is in the chain. After reset, with no requests, `gnt_o` is zero.
- R9: Queries granted in back-to-back cycles from different channels are in flight together. Each is reported with the timing of R3 or R5, independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| req_i | input | NUM_CH | Lookup request per channel, held until granted |
| qidx_i | input | NUM_CH*IDX_W | Column index per channel, channel c at bits c*IDX_W +: IDX_W |
| gnt_o | output | NUM_CH | One-hot grant, same cycle as the request |
| ent_vld_i | input | DEPTH | Valid bit per active-set entry |
| ent_idx_i | input | DEPTH*IDX_W | Column index per active-set entry, entry k at bits k*IDX_W +: IDX_W |
| hit_o | output | NUM_CH | One-cycle hit pulse per channel |
| miss_o | output | NUM_CH | One-cycle miss (timeout) pulse per channel |

## Verification
The bench builds the block with NUM_CH=3, DEPTH=4 and IDX_W=4. At that size every valid-bit pattern of the active set (all 16) can be crossed with every column index (all 16) from every channel. The entry values include a duplicated index, so first-match cancellation, masked entries and full misses are all reached, each with its exact reporting cycle. It then requests from every subset of channels at once. This exercises the round-robin order against a model in the bench and keeps up to three queries in flight in the chain together.

// File: rtl/lcam_pkg.sv
package lcam_pkg;
  // Width of a binary channel number, never below one bit.
  function automatic int id_width(input int n);
    int w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction
endpackage

// File: rtl/lcam_arb.sv
module lcam_arb #(
  parameter int N  = 4,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          sel_v,
  output logic [CW-1:0] sel_ch
);
  logic [CW-1:0] last_q;
  int            cand;

  // Next-state: first requester after the last winner, circular order.
  always_comb begin
    gnt    = '0;
    sel_v  = 1'b0;
    sel_ch = '0;
    cand   = 0;
    for (int k = 1; k <= N; k++) begin
      cand = (int'(last_q) + k) % N;
      if (!sel_v && req[cand]) begin
        sel_v     = 1'b1;
        sel_ch    = CW'(cand);
        gnt[cand] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= CW'(N - 1);
    end else if (sel_v) begin
      last_q <= sel_ch;
    end
  end
endmodule

// File: rtl/lcam_stage.sv
module lcam_stage #(
  parameter int IDX_W = 10,
  parameter int CW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_v,
  input  logic [CW-1:0]    up_ch,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             ent_v,
  input  logic [IDX_W-1:0] ent_idx,
  output logic             dn_v,
  output logic [CW-1:0]    dn_ch,
  output logic [IDX_W-1:0] dn_idx,
  output logic             match
);
  logic             r_v;
  logic [CW-1:0]    r_ch;
  logic [IDX_W-1:0] r_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_v   <= 1'b0;
      r_ch  <= '0;
      r_idx <= '0;
    end else begin
      r_v <= up_v;
      if (up_v) begin
        r_ch  <= up_ch;
        r_idx <= up_idx;
      end
    end
  end

  // Compare only against a populated entry; a match retires the query.
  always_comb begin
    match  = r_v && ent_v && (r_idx == ent_idx);
    dn_v   = r_v && !match;
    dn_ch  = r_ch;
    dn_idx = r_idx;
  end
endmodule

// File: rtl/lcam_report.sv
module lcam_report #(
  parameter int N     = 4,
  parameter int DEPTH = 16,
  parameter int CW    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEPTH-1:0]   match,
  input  logic [DEPTH*CW-1:0] stage_ch,
  input  logic               tail_v,
  input  logic [CW-1:0]      tail_ch,
  output logic [N-1:0]       hit_o,
  output logic [N-1:0]       miss_o
);
  logic [N-1:0] hit_d, miss_d;

  for (genvar c = 0; c < N; c++) begin : g_ch
    always_comb begin
      hit_d[c] = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        if (match[i] && (stage_ch[i*CW +: CW] == CW'(c))) hit_d[c] = 1'b1;
      end
      miss_d[c] = tail_v && (tail_ch == CW'(c));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o  <= '0;
      miss_o <= '0;
    end else begin
      hit_o  <= hit_d;
      miss_o <= miss_d;
    end
  end
endmodule

// File: rtl/lcam_top.sv
module lcam_top #(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       req_i,
  input  logic [NUM_CH*IDX_W-1:0] qidx_i,
  output logic [NUM_CH-1:0]       gnt_o,
  input  logic [DEPTH-1:0]        ent_vld_i,
  input  logic [DEPTH*IDX_W-1:0]  ent_idx_i,
  output logic [NUM_CH-1:0]       hit_o,
  output logic [NUM_CH-1:0]       miss_o
);
  localparam int CW = lcam_pkg::id_width(NUM_CH);

  logic             sel_v;
  logic [CW-1:0]    sel_ch;
  logic [DEPTH:0]   c_v;
  logic [CW-1:0]    c_ch  [DEPTH+1];
  logic [IDX_W-1:0] c_idx [DEPTH+1];
  logic [DEPTH-1:0] match;
  logic [DEPTH*CW-1:0] stage_ch;

  lcam_arb #(.N(NUM_CH), .CW(CW)) arb_i (
    .clk(clk), .rst_n(rst_n), .req(req_i), .gnt(gnt_o),
    .sel_v(sel_v), .sel_ch(sel_ch)
  );

  always_comb begin
    c_v[0]   = sel_v;
    c_ch[0]  = sel_ch;
    c_idx[0] = qidx_i[sel_ch*IDX_W +: IDX_W];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    lcam_stage #(.IDX_W(IDX_W), .CW(CW)) stage_i (
      .clk(clk), .rst_n(rst_n),
      .up_v(c_v[i]), .up_ch(c_ch[i]), .up_idx(c_idx[i]),
      .ent_v(ent_vld_i[i]), .ent_idx(ent_idx_i[i*IDX_W +: IDX_W]),
      .dn_v(c_v[i+1]), .dn_ch(c_ch[i+1]), .dn_idx(c_idx[i+1]),
      .match(match[i])
    );
    assign stage_ch[i*CW +: CW] = c_ch[i+1];
  end

  lcam_report #(.N(NUM_CH), .DEPTH(DEPTH), .CW(CW)) rep_i (
    .clk(clk), .rst_n(rst_n), .match(match), .stage_ch(stage_ch),
    .tail_v(c_v[DEPTH]), .tail_ch(c_ch[DEPTH]),
    .hit_o(hit_o), .miss_o(miss_o)
  );
endmodule

// File: rtl/lcam_chk.sv
module lcam_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] req_i,
  input logic [NUM_CH-1:0] gnt_o,
  input logic [NUM_CH-1:0] hit_o,
  input logic [NUM_CH-1:0] miss_o
);
  a_r1_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  a_r1_gnt_to_req: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o & ~req_i) == '0);

  a_r1_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |-> (|gnt_o));

  a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o & miss_o) == '0);

  a_r7_hit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_o) |=> ((hit_o & $past(hit_o)) == '0));

  a_r7_miss_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (|miss_o) |=> ((miss_o & $past(miss_o)) == '0));
endmodule

bind lcam_top lcam_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .gnt_o(gnt_o),
  .hit_o(hit_o), .miss_o(miss_o)
);

// File: tb/lcam_top_tb_top.sv
module lcam_top_tb_top;
  localparam int NCH = 3;
  localparam int DEP = 4;
  localparam int IW  = 4;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NCH-1:0]        req = '0;
  logic [NCH*IW-1:0]     qidx = '0;
  logic [NCH-1:0]        gnt;
  logic [DEP-1:0]        mask = '0;
  logic [DEP*IW-1:0]     ents;
  logic [NCH-1:0]        hit, miss;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_g = NCH - 1;
  int exp_cyc [NCH];
  bit exp_hit [NCH];
  bit mon_en = 1'b0;
  logic eh, em;

  // Entries 3, 9, 9, 14: entry 2 repeats entry 1.
  assign ents = {4'd14, 4'd9, 4'd9, 4'd3};

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lcam_top #(.NUM_CH(NCH), .DEPTH(DEP), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .qidx_i(qidx), .gnt_o(gnt),
    .ent_vld_i(mask), .ent_idx_i(ents), .hit_o(hit), .miss_o(miss)
  );

  function automatic int first_k(input int idx);
    for (int k = 0; k < DEP; k++)
      if (mask[k] && int'(ents[k*IW +: IW]) == idx) return k;
    return -1;
  endfunction

  // Per-channel outcome monitor (R3 R4 R5 R6 R7 R9).
  always @(negedge clk) begin
    if (mon_en) begin
      for (int c = 0; c < NCH; c++) begin
        eh = (cyc == exp_cyc[c]) && exp_hit[c];
        em = (cyc == exp_cyc[c]) && !exp_hit[c];
        n_chk++;
        if (hit[c] !== eh || miss[c] !== em) begin
          n_bad++;
          $display("FAIL %s ch%0d cyc%0d: hit=%b miss=%b expected hit=%b miss=%b",
                   (cyc == exp_cyc[c]) ? (exp_hit[c] ? "R3 R4 R6 hit" : "R5 miss")
                                       : "R6 R7 spurious",
                   c, cyc, hit[c], miss[c], eh, em);
        end
      end
    end
  end

  task automatic launch(input logic [NCH-1:0] want, input logic [NCH*IW-1:0] qv);
    logic [NCH-1:0] pend;
    int g, k;
    pend = want;
    while (pend != '0) begin
      @(negedge clk);
      req  = pend;
      qidx = qv;
      #1;
      g = -1;
      for (int s = 1; s <= NCH; s++)
        if (g < 0 && pend[(last_g + s) % NCH]) g = (last_g + s) % NCH;
      n_chk++;
      if (gnt !== NCH'(1 << g)) begin
        n_bad++;
        $display("FAIL R1 R2 grant: actual=%b expected=%b", gnt, NCH'(1 << g));
      end
      k = first_k(int'(qv[g*IW +: IW]));
      exp_hit[g] = (k >= 0);
      exp_cyc[g] = (k >= 0) ? cyc + k + 2 : cyc + DEP + 1;
      last_g = g;
      pend[g] = 1'b0;
      @(posedge clk);
    end
    @(negedge clk);
    req = '0;
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin exp_cyc[c] = -100; exp_hit[c] = 1'b0; end
    repeat (3) @(negedge clk);
    // R8: reset state
    n_chk++;
    if (hit !== '0 || miss !== '0) begin
      n_bad++;
      $display("FAIL R8 reset outputs: hit=%b miss=%b expected 0", hit, miss);
    end
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;
    n_chk++;
    if (gnt !== '0) begin
      n_bad++;
      $display("FAIL R8 idle grant: actual=%b expected=0", gnt);
    end
    // R3 R4 R5 R6: every mask x every index x every channel, one at a time.
    for (int m = 0; m < 16; m++) begin
      mask = DEP'(m);
      for (int ch = 0; ch < NCH; ch++)
        for (int ix = 0; ix < 16; ix++) begin
          launch(NCH'(1 << ch), {NCH{IW'(ix)}});
          repeat (DEP + 3) @(negedge clk);
        end
    end
    // R2 R9: simultaneous requests, queries overlap in the chain.
    mask = 4'b1011;
    for (int w = 1; w < 8; w++)
      for (int v = 0; v < 4; v++) begin
        launch(NCH'(w), {IW'(14 - v), IW'(9 + v), IW'(3 * v)});
        repeat (DEP + 4) @(negedge clk);
      end
    mon_en = 1'b0;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule